// File: doc/BRIEF.md
# Dithered PWM Timing Generator

This block produces the gate timing for a peak-current-mode switching converter. A digital period counter runs at a nominal switching rate, and a slow triangular modulator moves the reload value of that counter up and down by a fixed step every period. The switching frequency therefore wanders across a narrow band around its centre, which spreads conducted emissions. A one-bit select chooses between the normal rate and a slower light-load rate. In the slow rate the dither band is widened in the same proportion as the period.

Each period begins with a one-clock cycle-start strobe. The gate rises at that moment if the block is enabled. The gate falls at the earliest of three events: the duty-cycle limit, a current-limit trip seen after the blanking window, or the enable going low. A blanking flag stays high for a fixed number of clocks at the start of each pulse. While it is high, the digital trip flag from the external comparator is ignored, so the turn-on spike cannot end a pulse early. All outputs are registered.

Top module: `pwm_dither_gen`

## Requirements
- R1: While `rst` is high, `gate_o`, `start_o` and `blank_o` are low. The first `start_o` pulse is seen on the first clock after `rst` is released.
- R2: `start_o` is high for exactly one clock at the beginning of every period. Period length is the number of clocks from one `start_o` to the next.
- R3: A signed dither offset starts at 0 moving upward and changes by `DITHER_STEP` at every period start. It is clamped to plus or minus `PERIOD_DEV` and reverses direction in the period in which it reaches a band edge. With the normal rate, a period lasts `PERIOD_NOM` plus the offset held at its start.
- R4: `slow_sel_i` is sampled at each period start (1 = slow rate, 0 = normal rate). In the slow rate, a period lasts `PERIOD_GRN` plus or minus the scaled offset magnitude. The scaled magnitude is floor(|offset| x G / 256), with G = round(256 x `PERIOD_GRN` / `PERIOD_NOM`), and the offset's sign is kept.
- R5: When enable was high at the period start, `gate_o` rises together with `start_o`. It stays high for no more than floor(P x `DUTY_NUM` / 2^`DUTY_SHIFT`) clocks of a period of P clocks.
- R6: `blank_o` is high during the first `BLANK_CYC` clocks of each pulse, and only while `gate_o` is high.
- R7: A trip seen on `trip_i` while `blank_o` is high has no effect on the pulse.
- R8: A trip seen while `gate_o` is high and `blank_o` is low drives `gate_o` low on the next clock. The gate stays low until the next period start.
- R9: `en_i` low drives `gate_o` low on the next clock. Raising `en_i` in the middle of a period does not start a pulse before the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Switching enable |
| slow_sel_i | input | 1 | Rate select: 1 = light-load slow rate |
| trip_i | input | 1 | Digital current-limit trip flag |
| gate_o | output | 1 | Gate drive timing |
| start_o | output | 1 | One-clock period-start strobe |
| blank_o | output | 1 | Sense blanking active |

## Verification
The hardest situations to reach are the dither band edges, which occur many periods after reset, and the scaled slow-rate periods, which depend on where the sweep stands when the select changes. The stimulus handles both by driving every period in an unbroken run, so the band edges are crossed in both directions. The select is switched part way through the sweep. Trip pulses are placed a counted number of clocks after the start strobe. This puts one pulse inside the blanking window, one exactly at its end, and one later in the pulse. Enable is dropped and raised at period starts, which exposes the rule that a mid-period re-enable does not start a pulse.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;

  typedef enum logic {
    SWEEP_DOWN = 1'b0,
    SWEEP_UP   = 1'b1
  } sweep_dir_e;

  // Q8 ratio of two periods, rounded to nearest
  function automatic int gain_q8(input int num, input int den);
    return (num * 256 + den / 2) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwmdt_sweep.sv
module pwmdt_sweep
  import pwmdt_pkg::*;
#(
  parameter int DEV  = 118,
  parameter int STEP = 1,
  parameter int OW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv_i,
  output logic signed [OW-1:0] off_o
);

  logic signed [OW-1:0] off_q, off_n;
  sweep_dir_e           dir_q, dir_n;

  always_comb begin
    int cur;
    cur   = int'(off_q);
    off_n = off_q;
    dir_n = dir_q;
    if (dir_q == SWEEP_UP) begin
      if (cur + STEP >= DEV) begin
        off_n = OW'(DEV);
        dir_n = SWEEP_DOWN;
      end else begin
        off_n = OW'(cur + STEP);
      end
    end else begin
      if (cur - STEP <= -DEV) begin
        off_n = OW'(-DEV);
        dir_n = SWEEP_UP;
      end else begin
        off_n = OW'(cur - STEP);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      dir_q <= SWEEP_UP;
    end else if (adv_i) begin
      off_q <= off_n;
      dir_q <= dir_n;
    end
  end

  assign off_o = off_q;

endmodule

// File: rtl/pwmdt_timer.sv
module pwmdt_timer #(
  parameter int NOM        = 1923,
  parameter int GRN        = 5000,
  parameter int GAIN       = 666,
  parameter int DUTY_NUM   = 3,
  parameter int DUTY_SHIFT = 2,
  parameter int CW         = 13,
  parameter int OW         = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_i,
  input  logic signed [OW-1:0] off_i,
  output logic [CW-1:0]        cnt_o,
  output logic [CW-1:0]        ton_o,
  output logic                 wrap_o
);

  localparam int GW = $clog2(GAIN + 1) + 1;
  localparam int MW = CW + OW + GW;

  logic signed [OW-1:0] neg_off;
  logic [OW-1:0]        mag;
  logic [MW-1:0]        mag_sc, step, base, per_n, ton_n;
  logic [CW-1:0]        cnt_q, per_q, ton_q;

  assign neg_off = -off_i;
  assign mag     = off_i[OW-1] ? neg_off : off_i;

  // unity ratio needs no multiplier
  generate
    if (GAIN == 256) begin : g_unity
      assign mag_sc = MW'(mag);
    end else begin : g_scale
      assign mag_sc = (MW'(mag) * MW'(GAIN)) >> 8;
    end
  endgenerate

  assign step   = sel_i ? mag_sc : MW'(mag);
  assign base   = sel_i ? MW'(GRN) : MW'(NOM);
  assign per_n  = off_i[OW-1] ? (base - step) : (base + step);
  assign ton_n  = (per_n * MW'(DUTY_NUM)) >> DUTY_SHIFT;
  assign wrap_o = (cnt_q == per_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= CW'(NOM);
      cnt_q <= CW'(NOM - 1);
      ton_q <= CW'((NOM * DUTY_NUM) >> DUTY_SHIFT);
    end else if (wrap_o) begin
      cnt_q <= '0;
      per_q <= CW'(per_n);
      ton_q <= CW'(ton_n);
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign ton_o = ton_q;

endmodule

// File: rtl/pwmdt_pulse.sv
module pwmdt_pulse #(
  parameter int CW    = 13,
  parameter int BLANK = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] ton_i,
  input  logic          en_i,
  input  logic          trip_i,
  output logic          gate_o,
  output logic          blank_o,
  output logic          start_o
);

  logic          gate_q, blank_q, start_q;
  logic          gate_n, blank_n;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_i + CW'(1);

  always_comb begin
    gate_n  = gate_q;
    blank_n = 1'b0;
    if (wrap_i) begin
      gate_n  = en_i;
      blank_n = en_i && (BLANK > 0);
    end else begin
      if (!en_i)
        gate_n = 1'b0;
      else if (gate_q && (cnt_inc == ton_i))
        gate_n = 1'b0;
      else if (gate_q && trip_i && !blank_q)
        gate_n = 1'b0;
      blank_n = blank_q && gate_n && (cnt_inc < CW'(BLANK));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      blank_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      gate_q  <= gate_n;
      blank_q <= blank_n;
      start_q <= wrap_i;
    end
  end

  assign gate_o  = gate_q;
  assign blank_o = blank_q;
  assign start_o = start_q;

endmodule

// File: rtl/pwm_dither_gen.sv
module pwm_dither_gen
  import pwmdt_pkg::*;
#(
  parameter int PERIOD_NOM  = 1923,
  parameter int PERIOD_GRN  = 5000,
  parameter int PERIOD_DEV  = 118,
  parameter int DITHER_STEP = 1,
  parameter int BLANK_CYC   = 31,
  parameter int DUTY_NUM    = 3,
  parameter int DUTY_SHIFT  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic slow_sel_i,
  input  logic trip_i,
  output logic gate_o,
  output logic start_o,
  output logic blank_o
);

  localparam int GRN_GAIN = gain_q8(PERIOD_GRN, PERIOD_NOM);
  localparam int DEV_GRN  = (PERIOD_DEV * GRN_GAIN) >> 8;
  localparam int PMAX     = max2(PERIOD_NOM + PERIOD_DEV, PERIOD_GRN + DEV_GRN);
  localparam int CW       = $clog2(PMAX + 1);
  localparam int OW       = $clog2(PERIOD_DEV + DITHER_STEP + 1) + 1;

  logic signed [OW-1:0] offset;
  logic [CW-1:0]        cnt, ton;
  logic                 wrap;

  pwmdt_sweep #(
    .DEV  (PERIOD_DEV),
    .STEP (DITHER_STEP),
    .OW   (OW)
  ) u_sweep (
    .clk   (clk),
    .rst   (rst),
    .adv_i (wrap),
    .off_o (offset)
  );

  pwmdt_timer #(
    .NOM        (PERIOD_NOM),
    .GRN        (PERIOD_GRN),
    .GAIN       (GRN_GAIN),
    .DUTY_NUM   (DUTY_NUM),
    .DUTY_SHIFT (DUTY_SHIFT),
    .CW         (CW),
    .OW         (OW)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (slow_sel_i),
    .off_i  (offset),
    .cnt_o  (cnt),
    .ton_o  (ton),
    .wrap_o (wrap)
  );

  pwmdt_pulse #(
    .CW    (CW),
    .BLANK (BLANK_CYC)
  ) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .wrap_i  (wrap),
    .cnt_i   (cnt),
    .ton_i   (ton),
    .en_i    (en_i),
    .trip_i  (trip_i),
    .gate_o  (gate_o),
    .blank_o (blank_o),
    .start_o (start_o)
  );

endmodule

// File: rtl/pwm_dither_gen_chk.sv
module pwm_dither_gen_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic trip_i,
  input logic gate_o,
  input logic start_o,
  input logic blank_o
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!gate_o && !start_o && !blank_o));

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R5
  gate_rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> start_o);

  // R5
  duty_gap_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !$past(gate_o));

  // R6
  blank_in_gate_chk: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> gate_o);

  // R8
  trip_ends_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_o && !blank_o && trip_i) |=> (!gate_o || start_o));

  // R9
  disable_drops_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !gate_o);

endmodule

bind pwm_dither_gen pwm_dither_gen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .en_i    (en_i),
  .trip_i  (trip_i),
  .gate_o  (gate_o),
  .start_o (start_o),
  .blank_o (blank_o)
);

// File: tb/pwm_dither_gen_bench.sv
module pwm_dither_gen_bench;

  localparam int NOM   = 40;
  localparam int GRN   = 100;
  localparam int DEV   = 6;
  localparam int STEP  = 2;
  localparam int BLANK = 4;
  localparam int DNUM  = 3;
  localparam int DSH   = 2;
  localparam int GAIN  = (GRN * 256 + NOM / 2) / NOM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b1;
  logic slow_sel_i = 1'b0;
  logic trip_i = 1'b0;
  logic gate_o, start_o, blank_o;

  always #4 clk = ~clk;

  pwm_dither_gen #(
    .PERIOD_NOM  (NOM),
    .PERIOD_GRN  (GRN),
    .PERIOD_DEV  (DEV),
    .DITHER_STEP (STEP),
    .BLANK_CYC   (BLANK),
    .DUTY_NUM    (DNUM),
    .DUTY_SHIFT  (DSH)
  ) u_pwm_dither_gen (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .slow_sel_i (slow_sel_i),
    .trip_i     (trip_i),
    .gate_o     (gate_o),
    .start_o    (start_o),
    .blank_o    (blank_o)
  );

  typedef struct {
    int    per;
    int    on;
    int    bl;
    string ptag;
    string otag;
    string btag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // reference model state
  int m_off  = 0;
  bit m_up   = 1'b1;
  bit m_sel  = 1'b0;
  bit m_en   = 1'b1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // driver: one call per period, inputs changed at the start strobe
  task automatic do_cycle(input bit en_now, input bit sel_next, input int trip_at,
                          input string otag, output int waited);
    exp_t e;
    int   mag, sc, lim;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!start_o);
    mag = (m_off < 0) ? -m_off : m_off;
    sc  = m_sel ? ((mag * GAIN) >> 8) : mag;
    e.per  = (m_sel ? GRN : NOM) + ((m_off < 0) ? -sc : sc);
    e.ptag = m_sel ? "R4" : "R3";
    if (m_up) begin
      if (m_off + STEP >= DEV) begin m_off = DEV; m_up = 1'b0; end
      else m_off = m_off + STEP;
    end else begin
      if (m_off - STEP <= -DEV) begin m_off = -DEV; m_up = 1'b1; end
      else m_off = m_off - STEP;
    end
    lim = (e.per * DNUM) >> DSH;
    if (!m_en) begin
      e.on = 0; e.bl = 0;
    end else if (!en_now) begin
      e.on = 1; e.bl = 1;
    end else begin
      e.on = (trip_at >= BLANK) ? ((trip_at + 1 < lim) ? trip_at + 1 : lim) : lim;
      e.bl = (BLANK < e.on) ? BLANK : e.on;
    end
    e.otag = otag;
    e.btag = (trip_at >= 0 && trip_at < BLANK) ? "R7" : "R6";
    exp_q.push_back(e);
    m_en       = en_now;
    m_sel      = sel_next;
    en_i       = en_now;
    slow_sel_i = sel_next;
    if (trip_at >= 0) begin
      repeat (trip_at) @(negedge clk);
      trip_i = 1'b1;
      @(negedge clk);
      trip_i = 1'b0;
    end
  endtask

  // monitor: measures each completed period and compares with the queue
  initial begin
    int  per, on, bl;
    bit  open;
    exp_t e;
    open = 1'b0;
    per = 0; on = 0; bl = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (start_o) begin
          if (open) begin
            if (exp_q.size() == 0) begin
              chk("R2", "unexpected period", 1, 0);
            end else begin
              e = exp_q.pop_front();
              chk(e.ptag, "period", per, e.per);
              chk(e.otag, "on-time", on, e.on);
              chk(e.btag, "blank length", bl, e.bl);
            end
          end
          open = 1'b1;
          per = 1;
          on  = gate_o ? 1 : 0;
          bl  = blank_o ? 1 : 0;
        end else if (open) begin
          per++;
          on += gate_o ? 1 : 0;
          bl += blank_o ? 1 : 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int w;
    repeat (4) begin
      @(negedge clk);
      chk("R1", "gate in reset", int'(gate_o), 0);
      chk("R1", "start in reset", int'(start_o), 0);
      chk("R1", "blank in reset", int'(blank_o), 0);
    end
    rst = 1'b0;
    do_cycle(1'b1, 1'b0, -1, "R5", w);
    chk("R1", "clocks to first start", w, 1);
    // sweep through both band edges (R3)
    for (int i = 0; i < 11; i++) do_cycle(1'b1, 1'b0, -1, "R5", w);
    // R7: trip inside blanking is ignored
    do_cycle(1'b1, 1'b0, 2, "R7", w);
    // R8: trip exactly when blanking ends, and later in the pulse
    do_cycle(1'b1, 1'b0, BLANK, "R8", w);
    do_cycle(1'b1, 1'b0, 10, "R8", w);
    // R9: disable, hold off, re-enable mid-period, resume
    do_cycle(1'b0, 1'b0, -1, "R9", w);
    do_cycle(1'b0, 1'b0, -1, "R9", w);
    do_cycle(1'b1, 1'b0, -1, "R9", w);
    do_cycle(1'b1, 1'b0, -1, "R9", w);
    // R4: slow rate with scaled dither
    do_cycle(1'b1, 1'b1, -1, "R5", w);
    for (int i = 0; i < 4; i++) do_cycle(1'b1, 1'b1, -1, "R5", w);
    do_cycle(1'b1, 1'b1, 20, "R8", w);
    do_cycle(1'b1, 1'b0, -1, "R5", w);
    do_cycle(1'b1, 1'b0, -1, "R5", w);
    do_cycle(1'b1, 1'b0, -1, "R5", w);
    // let the monitor close the last period
    do begin
      @(negedge clk);
    end while (!start_o);
    @(posedge clk);
    chk("R2", "leftover expected periods", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule